// File: doc/BRIEF.md
# Keyed Watchdog Timer with Forced Overflow

This block is a watchdog counter that advances on a prescaled tick and asserts an overflow pulse, meant as a reset request, when software fails to restart it in time. Software restarts the count by writing a fixed key byte to a key register. A mode register picks one of eight interval taps. After reset that register accepts exactly one ordinary write, and a write of zero is accepted at any time and stops the watchdog for good.

Several misuse patterns count as evidence of runaway software and fire the overflow at once: a wrong key byte, a single-bit read-modify-write access to the key register, or a second ordinary write to the mode register. Once the timer is stopped, none of these misuse patterns fires. Reading the key register always returns a fixed tag byte that differs from the key. Reading the mode register returns the stored mode byte.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is high and in the first cycle after it, `wdt_ovf` is 0. The mode register reads 07H after reset.
- R2: A read of the key register (address 1) returns 9AH one cycle after the address is presented, whatever was written before.
- R3: A first mode write of a nonzero byte selects tap `t` = byte bits [2:0]. With the tick held high, the overflow pulse follows the write edge by exactly 2^(t+BASE_SHIFT) clock edges.
- R4: Without any mode write after reset, the interval is the longest one, 2^(7+BASE_SHIFT) ticks, counted from reset release.
- R5: Writing ACH with `bus_bit`=0 to the key register clears the count, so the next overflow comes a full interval after that write.
- R6: While running, writing any byte other than ACH to the key register raises `wdt_ovf` in the cycle after the write edge.
- R7: While running, a key register write with `bus_bit`=1 raises `wdt_ovf` in the cycle after the write edge, even if the data is ACH.
- R8: While running, a second nonzero mode write raises `wdt_ovf` in the cycle after the write edge and leaves the stored mode unchanged.
- R9: Writing 00H to the mode register is accepted even after a first mode write. It produces no overflow, stops the counter permanently until reset, and the mode register then reads 00H.
- R10: While stopped, a wrong key, a bit-level key access and a further mode write produce no overflow and leave the mode reading 00H.
- R11: The overflow is a one-cycle pulse. The count restarts from zero and the next natural overflow follows a full interval later.
- R12: The count advances only on clock edges where `tick` is 1.
- R13: If a valid key write lands on the edge where the count would expire, the restart wins: no pulse is produced, and the next overflow comes a full interval later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| bus_addr | input | ADDR_W | Register address (0 mode, 1 key) |
| bus_wr | input | 1 | Write strobe |
| bus_bit | input | 1 | Marks the access as a single-bit read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| wdt_ovf | output | 1 | One-cycle overflow (reset request) pulse |

## Verification
The collision that matters is a valid key restart landing on the same edge as a natural expiry. The bench provokes it by restarting the timer and then placing a second key write exactly one interval of edges later, with the tick held high. It judges the result by seeing no pulse on that edge and a pulse a full interval after it. A second overlap, an expiry that falls during reads and resets, is covered by the tap sweep, which counts the edges to each pulse arithmetically against 2^(t+BASE_SHIFT).

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int         DW        = 8;
  localparam logic [7:0] KEY_CODE  = 8'hAC;
  localparam logic [7:0] KEY_READ  = 8'h9A;
  localparam logic [7:0] STOP_CODE = 8'h00;

  // decoded bus events for one cycle
  typedef struct packed {
    logic restart;    // valid key write
    logic force_ovf;  // misuse while running
    logic mode_load;  // first ordinary mode write
    logic stop;       // stop request
  } kwdt_evt_t;

endpackage

// File: rtl/kwdt_access_decode.sv
module kwdt_access_decode
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 0,
  parameter int KEY_ADDR  = 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_bit,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              locked,
  input  logic              running,
  output kwdt_evt_t         evt
);

  logic key_hit, mode_hit, key_good, key_fault, mode_stop, mode_again;

  always_comb begin
    key_hit    = bus_wr && (bus_addr == ADDR_W'(KEY_ADDR));
    mode_hit   = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));
    key_good   = key_hit && !bus_bit && (bus_wdata == KEY_CODE);
    key_fault  = key_hit && (bus_bit || (bus_wdata != KEY_CODE));
    mode_stop  = mode_hit && (bus_wdata == STOP_CODE);
    mode_again = mode_hit && locked && (bus_wdata != STOP_CODE);

    evt.restart   = key_good;
    evt.stop      = mode_stop;
    evt.mode_load = mode_hit && !locked && (bus_wdata != STOP_CODE);
    evt.force_ovf = running && (key_fault || mode_again);
  end

endmodule

// File: rtl/kwdt_mode_reg.sv
module kwdt_mode_reg
  import kwdt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  kwdt_evt_t        evt,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    mode_q,
  output logic [SEL_W-1:0] tap,
  output logic             running,
  output logic             locked
);

  localparam logic [DW-1:0] RESET_MODE = DW'((1 << SEL_W) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= RESET_MODE;
      running <= 1'b1;
      locked  <= 1'b0;
    end else if (evt.stop) begin
      mode_q  <= STOP_CODE;
      running <= 1'b0;
      locked  <= 1'b1;
    end else if (evt.mode_load) begin
      mode_q  <= bus_wdata;
      locked  <= 1'b1;
    end
  end

  assign tap = mode_q[SEL_W-1:0];

  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !running);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !evt.stop) |=> $stable(mode_q));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int BASE_SHIFT = 9,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             running,
  input  logic [SEL_W-1:0] tap,
  input  logic             clear,
  output logic             expire
);

  localparam int CW = BASE_SHIFT + (1 << SEL_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW:0]   span;
  logic [CW-1:0] last;

  always_comb begin
    span   = (CW+1)'(1) << (32'(tap) + BASE_SHIFT);
    last   = CW'(span - (CW+1)'(1));
    expire = running && tick && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || expire) cnt <= '0;
    else if (running && tick)   cnt <= cnt + CW'(1);
  end

  // R12
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(cnt));

  // R11
  wrap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MODE_ADDR  = 0,
  parameter int KEY_ADDR   = 1,
  parameter int BASE_SHIFT = 9,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_bit,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_ovf
);

  kwdt_evt_t        evt;
  logic [DW-1:0]    mode_q;
  logic [SEL_W-1:0] tap;
  logic             running, locked, expire;

  kwdt_access_decode #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR)
  ) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_bit(bus_bit),
    .bus_wdata(bus_wdata), .locked(locked), .running(running), .evt(evt)
  );

  kwdt_mode_reg #(.SEL_W(SEL_W)) u_mode (
    .clk(clk), .rst(rst), .evt(evt), .bus_wdata(bus_wdata),
    .mode_q(mode_q), .tap(tap), .running(running), .locked(locked)
  );

  kwdt_counter #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .running(running), .tap(tap),
    .clear(evt.restart | evt.mode_load | evt.force_ovf), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_ovf   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      wdt_ovf <= evt.force_ovf | (expire & ~evt.restart & ~evt.mode_load);
      if (bus_addr == ADDR_W'(KEY_ADDR))       bus_rdata <= KEY_READ;
      else if (bus_addr == ADDR_W'(MODE_ADDR)) bus_rdata <= mode_q;
      else                                     bus_rdata <= '0;
    end
  end

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (running && bus_wr && bus_addr == ADDR_W'(KEY_ADDR) && bus_wdata != KEY_CODE)
    |=> wdt_ovf);

  // R7
  bit_access_chk: assert property (@(posedge clk) disable iff (rst)
    (running && bus_wr && bus_bit && bus_addr == ADDR_W'(KEY_ADDR)) |=> wdt_ovf);

  // R8
  second_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (running && locked && bus_wr && bus_addr == ADDR_W'(MODE_ADDR) &&
     bus_wdata != STOP_CODE) |=> wdt_ovf);

  // R10
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !wdt_ovf);

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_bit = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wdt_ovf;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog #(.BASE_SHIFT(BASE)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_bit(bus_bit), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_ovf(wdt_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_bit = 1'b0; tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic b);
    bus_addr = a; bus_wdata = d; bus_bit = b; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_bit = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  // edges until the next pulse, -1 if none within limit
  task automatic wait_ovf(input int limit, output int n);
    bit found = 1'b0;
    int i = 0;
    n = -1;
    while (!found && i < limit) begin
      @(posedge clk);
      @(negedge clk);
      i++;
      if (wdt_ovf) begin found = 1'b1; n = i; end
    end
  endtask

  initial begin
    logic [7:0] d;
    int n;

    // R1 reset state
    @(negedge clk);
    check(wdt_ovf == 1'b0, "R1 ovf in reset", wdt_ovf, 0);
    do_reset();
    check(wdt_ovf == 1'b0, "R1 ovf after reset", wdt_ovf, 0);
    rd(4'd0, d);
    check(d == 8'h07, "R1 mode reset value", d, 8'h07);

    // R4 default interval, R11 pulse width and repeat
    do_reset();
    wait_ovf(1000, n);
    check(n == (1 << (7+BASE)), "R4 default interval", n, 1 << (7+BASE));
    @(posedge clk); @(negedge clk);
    check(wdt_ovf == 1'b0, "R11 pulse width", wdt_ovf, 0);
    wait_ovf(1000, n);
    check(n + 1 == (1 << (7+BASE)), "R11 next interval", n + 1, 1 << (7+BASE));

    // R3 tap sweep
    for (int t = 0; t < 8; t++) begin
      do_reset();
      wr(4'd0, 8'h08 | 8'(t), 1'b0);
      wait_ovf(1000, n);
      check(n == (1 << (t+BASE)), $sformatf("R3 tap %0d", t), n, 1 << (t+BASE));
      rd(4'd0, d);
      check(d == (8'h08 | 8'(t)), "R3 mode readback", d, 8'h08 | t);
    end

    // R5 keyed restart, R2 readback
    do_reset();
    wr(4'd0, 8'h0A, 1'b0);
    repeat (10) begin @(posedge clk); @(negedge clk); end
    wr(4'd1, 8'hAC, 1'b0);
    wait_ovf(100, n);
    check(n == 16, "R5 restart interval", n, 16);
    rd(4'd1, d);
    check(d == 8'h9A, "R2 key readback", d, 8'h9A);

    // R6 wrong key
    do_reset();
    wr(4'd0, 8'h0C, 1'b0);
    wr(4'd1, 8'h55, 1'b0);
    check(wdt_ovf == 1'b1, "R6 wrong key forces", wdt_ovf, 1);
    wait_ovf(200, n);
    check(n == 64, "R11 count cleared by force", n, 64);
    rd(4'd1, d);
    check(d == 8'h9A, "R2 readback after wrong key", d, 8'h9A);

    // R7 bit access
    do_reset();
    wr(4'd0, 8'h0C, 1'b0);
    wr(4'd1, 8'hAC, 1'b1);
    check(wdt_ovf == 1'b1, "R7 bit access forces", wdt_ovf, 1);

    // R8 second mode write
    do_reset();
    wr(4'd0, 8'h0B, 1'b0);
    wr(4'd0, 8'h0D, 1'b0);
    check(wdt_ovf == 1'b1, "R8 second mode write forces", wdt_ovf, 1);
    rd(4'd0, d);
    check(d == 8'h0B, "R8 mode unchanged", d, 8'h0B);

    // R9 stop after a first write
    do_reset();
    wr(4'd0, 8'h0B, 1'b0);
    wr(4'd0, 8'h00, 1'b0);
    check(wdt_ovf == 1'b0, "R9 stop no pulse", wdt_ovf, 0);
    wait_ovf(1000, n);
    check(n == -1, "R9 stopped no overflow", n, -1);
    rd(4'd0, d);
    check(d == 8'h00, "R9 mode reads stop", d, 0);

    // R10 misuse while stopped
    wr(4'd1, 8'h55, 1'b0);
    check(wdt_ovf == 1'b0, "R10 wrong key stopped", wdt_ovf, 0);
    wr(4'd0, 8'h0F, 1'b0);
    check(wdt_ovf == 1'b0, "R10 mode write stopped", wdt_ovf, 0);
    wr(4'd1, 8'hAC, 1'b1);
    check(wdt_ovf == 1'b0, "R10 bit access stopped", wdt_ovf, 0);
    rd(4'd0, d);
    check(d == 8'h00, "R10 mode still stop", d, 0);
    wait_ovf(1000, n);
    check(n == -1, "R10 no later overflow", n, -1);

    // R9 stop as first write
    do_reset();
    wr(4'd0, 8'h00, 1'b0);
    wait_ovf(1000, n);
    check(n == -1, "R9 stop from reset", n, -1);

    // R12 tick gating
    do_reset();
    tick = 1'b0;
    wr(4'd0, 8'h08, 1'b0);
    wait_ovf(20, n);
    check(n == -1, "R12 no advance without tick", n, -1);
    tick = 1'b1;
    wait_ovf(100, n);
    check(n == 4, "R12 interval after tick resumes", n, 4);

    // R13 restart on the expiry edge
    do_reset();
    wr(4'd0, 8'h09, 1'b0);
    wr(4'd1, 8'hAC, 1'b0);
    wait_ovf(7, n);
    check(n == -1, "R13 no early pulse", n, -1);
    wr(4'd1, 8'hAC, 1'b0);
    check(wdt_ovf == 1'b0, "R13 restart beats expiry", wdt_ovf, 0);
    wait_ovf(100, n);
    check(n == 8, "R13 next full interval", n, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule